// File: doc/BRIEF.md
# Setup-Mode Configuration Register Bank

This block keeps the configuration of a group of on-board I/O functions in three byte-wide registers: a device control register, a diskette-controller arbitration register and a parallel-port arbitration register. Software reaches the registers through a small register-select port. Access works only while a setup-mode input is held high. At other times the bank ignores writes and returns no read data.

From the stored bytes the block decodes the enable for each device under one master enable. It also produces an output-only flag for the parallel port, burst and fairness controls and an arbitration level for the diskette controller, and an arbitration level for the parallel port. For the parallel port it gives a base address, a fixed interrupt level and an address-hit flag. The hit flag compares an incoming 16-bit port address against one of four fixed, non-contiguous windows, and one select code uses a different window for DMA cycles. The interrupt request lines of the devices pass through without change.

Top module: `setup_cfg_bank`

## Requirements
- R1: While `setup_en` is low, writes leave every register unchanged and `rdata` is 0 with `rdata_vld` low. While `setup_en` is high, `rd_en` gives `rdata_vld` high and the selected register on `rdata` in the same cycle.
- R2: A write with `setup_en` and `wr_en` high is captured at the rising clock edge. From then on it shows on `rdata` and on every decoded output. Register select `reg_sel` is 0 for control, 1 for diskette arbitration, 2 for parallel-port arbitration, and 3 is unused: it reads 0 and ignores writes.
- R3: In the control register, bit 0 is the master enable, bit 1 the diskette enable, bit 4 the parallel-port enable, bits 6:5 the window select and bit 7 the output-only bit. Bit 3 always reads 1 and bit 2 always reads 0, whatever is written to them.
- R4: `fdc_en` is high only when bits 1 and 0 are both 1. `pp_en` is high only when bits 4 and 0 are both 1.
- R5: When bit 0 is 0, `ser_en`, `fdc_en`, `pp_en` and `port_hit` are all low, whatever the other enable bits hold.
- R6: `pp_out_only` follows bit 7. It is 0 (bidirectional) after reset.
- R7: Window select 00 gives ports 0x03BC–0x03BF, 01 gives 0x0378–0x037D, 10 gives 0x0278–0x027D and 11 gives 0x1378–0x137D. `pp_base` shows the first port of the window in use. `pp_irq_lvl` is always 7.
- R8: With select 00 and `port_dma` high, the window in use is 0x1278–0x127D. For the other select codes `port_dma` has no effect.
- R9: `port_hit` is high when `port_addr` lies inside the window in use, both end ports included, and `pp_en` is high. Otherwise it is low.
- R10: In the diskette arbitration register, bits 3:0 drive `fdc_arb`, bit 4 drives `fdc_fair_en` and bit 5 drives `fdc_burst_dis`. Bits 7:6 read 0 and ignore writes.
- R11: In the parallel-port arbitration register, bits 3:0 drive `pp_arb`. Bits 7:4 read 0 and ignore writes.
- R12: `irq_out` equals `irq_in` at all times, whatever the enable bits hold.
- R13: After reset the control register reads 0x08, the diskette arbitration register reads 0x02 (level 2) and the parallel-port arbitration register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| setup_en | input | 1 | Setup mode; register access allowed only while high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_sel | input | 2 | Register select (0 control, 1 diskette arb, 2 port arb) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_vld | output | 1 | Read data valid |
| ser_en | output | 1 | Serial ports enable (master enable) |
| fdc_en | output | 1 | Diskette controller enable |
| pp_en | output | 1 | Parallel port enable |
| pp_out_only | output | 1 | Parallel port output-only mode |
| fdc_burst_dis | output | 1 | Diskette burst transfers disabled |
| fdc_fair_en | output | 1 | Diskette fairness enabled |
| fdc_arb | output | 4 | Diskette arbitration level |
| pp_arb | output | 4 | Parallel port arbitration level |
| pp_irq_lvl | output | 4 | Parallel port interrupt level |
| pp_base | output | 16 | First port of the selected window |
| port_addr | input | 16 | Incoming port address |
| port_dma | input | 1 | Incoming access is a DMA cycle |
| port_hit | output | 1 | Port address inside enabled window |
| irq_in | input | 4 | Device interrupt requests |
| irq_out | output | 4 | Interrupt requests passed through |

## Verification
Read data is combinational, so it is due in the same cycle as `rd_en`. The bench drives at the falling edge and samples one time unit later. A write is due at the first rising edge after it is driven. The bench drops the strobe at the next falling edge and samples the read path and the decoded outputs there, one edge after the write. The window base, the hit flag and the interrupt pass-through are combinational in `port_addr`, `port_dma` and `irq_in`, so they are checked one time unit after those inputs change, with no clock edge between.

// File: rtl/cfgbank_pkg.sv
// Shared types and constants for the setup-mode configuration bank.
// Assumes byte-wide registers and 16-bit port addresses.
package cfgbank_pkg;

    localparam int REG_W   = 8;
    localparam int PORT_AW = 16;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_FDC_ARB = 2'd1,
        SEL_PP_ARB  = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    // control register bit positions (decoded by neighbours)
    localparam int CB_MASTER  = 0;
    localparam int CB_FDC     = 1;
    localparam int CB_PP      = 4;
    localparam int CB_SEL_LO  = 5;
    localparam int CB_OUTONLY = 7;

    localparam logic [REG_W-1:0] CTRL_WMASK  = 8'hF3;
    localparam logic [REG_W-1:0] CTRL_FIXED1 = 8'h08;

    typedef struct packed {
        logic [PORT_AW-1:0] first;
        logic [PORT_AW-1:0] last;
    } port_win_t;

    // Fixed window lookup for the parallel port.
    function automatic port_win_t window_of(input logic [1:0] sel, input logic dma);
        port_win_t w;
        unique case (sel)
            2'b00:   w = dma ? '{16'h1278, 16'h127D} : '{16'h03BC, 16'h03BF};
            2'b01:   w = '{16'h0378, 16'h037D};
            2'b10:   w = '{16'h0278, 16'h027D};
            default: w = '{16'h1378, 16'h137D};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/cfgbank_regs.sv
// Register storage and read path for the three configuration bytes.
// Assumes: access gated by setup_en; reserved bits are never stored.
module cfgbank_regs
    import cfgbank_pkg::*;
#(
    parameter int ARB_W       = 4,
    parameter int FDC_ARB_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_en,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       reg_sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             rdata_vld,
    output logic [REG_W-1:0] ctrl_byte,
    output logic [REG_W-1:0] fdc_byte,
    output logic [REG_W-1:0] pp_byte
);
    localparam logic [REG_W-1:0] FDC_WMASK = REG_W'((1 << (ARB_W + 2)) - 1);
    localparam logic [REG_W-1:0] PP_WMASK  = REG_W'((1 << ARB_W) - 1);
    localparam logic [REG_W-1:0] FDC_RST   = REG_W'(FDC_ARB_RST);

    logic [REG_W-1:0] ctrl_q, fdc_q, pp_q;
    logic             wr_ok;

    assign wr_ok = setup_en && wr_en;

    // Capture accepted writes, keeping only writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            fdc_q  <= FDC_RST;
            pp_q   <= '0;
        end else if (wr_ok) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_CTRL:    ctrl_q <= wdata & CTRL_WMASK;
                SEL_FDC_ARB: fdc_q  <= wdata & FDC_WMASK;
                SEL_PP_ARB:  pp_q   <= wdata & PP_WMASK;
                default:     ;
            endcase
        end
    end

    assign ctrl_byte = ctrl_q | CTRL_FIXED1;
    assign fdc_byte  = fdc_q;
    assign pp_byte   = pp_q;

    // Select read data; nothing driven outside setup mode.
    always_comb begin
        rdata_vld = setup_en && rd_en;
        rdata     = '0;
        if (rdata_vld) begin
            unique case (reg_sel_e'(reg_sel))
                SEL_CTRL:    rdata = ctrl_byte;
                SEL_FDC_ARB: rdata = fdc_byte;
                SEL_PP_ARB:  rdata = pp_byte;
                default:     rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/cfgbank_enables.sv
// Decodes the control byte into device enables under the master bit.
// Assumes the byte layout given in cfgbank_pkg.
module cfgbank_enables
    import cfgbank_pkg::*;
(
    input  logic [REG_W-1:0] ctrl_byte,
    output logic             ser_en,
    output logic             fdc_en,
    output logic             pp_en,
    output logic             pp_out_only,
    output logic [1:0]       win_sel
);
    // Gate each device enable with the master enable.
    always_comb begin
        ser_en      = ctrl_byte[CB_MASTER];
        fdc_en      = ctrl_byte[CB_MASTER] & ctrl_byte[CB_FDC];
        pp_en       = ctrl_byte[CB_MASTER] & ctrl_byte[CB_PP];
        pp_out_only = ctrl_byte[CB_OUTONLY];
        win_sel     = ctrl_byte[CB_SEL_LO +: 2];
    end

endmodule

// File: rtl/cfgbank_window.sv
// Parallel port window: base address and inclusive range hit.
// Assumes windows are fixed; hit is forced low while disabled.
module cfgbank_window
    import cfgbank_pkg::*;
(
    input  logic [1:0]         win_sel,
    input  logic               dma,
    input  logic               enable,
    input  logic [PORT_AW-1:0] port_addr,
    output logic [PORT_AW-1:0] base,
    output logic               hit
);
    port_win_t win;

    // Look up the window and compare both ends.
    always_comb begin
        win  = window_of(win_sel, dma);
        base = win.first;
        hit  = enable && (port_addr >= win.first) && (port_addr <= win.last);
    end

endmodule

// File: rtl/setup_cfg_bank.sv
// Top of the setup-mode configuration bank: registers, enable decode,
// port window and interrupt pass-through. Assumes a synchronous
// active-low reset and a single clock.
module setup_cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int ARB_W        = 4,
    parameter int FDC_ARB_RST  = 2,
    parameter int IRQ_N        = 4,
    parameter int LVL_W        = 4,
    parameter int PP_IRQ_LEVEL = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               setup_en,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         reg_sel,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output logic               rdata_vld,
    output logic               ser_en,
    output logic               fdc_en,
    output logic               pp_en,
    output logic               pp_out_only,
    output logic               fdc_burst_dis,
    output logic               fdc_fair_en,
    output logic [ARB_W-1:0]   fdc_arb,
    output logic [ARB_W-1:0]   pp_arb,
    output logic [LVL_W-1:0]   pp_irq_lvl,
    output logic [15:0]        pp_base,
    input  logic [15:0]        port_addr,
    input  logic               port_dma,
    output logic               port_hit,
    input  logic [IRQ_N-1:0]   irq_in,
    output logic [IRQ_N-1:0]   irq_out
);
    logic [REG_W-1:0] ctrl_byte, fdc_byte, pp_byte;
    logic [1:0]       win_sel;

    cfgbank_regs #(
        .ARB_W      (ARB_W),
        .FDC_ARB_RST(FDC_ARB_RST)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .setup_en (setup_en),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .reg_sel  (reg_sel),
        .wdata    (wdata),
        .rdata    (rdata),
        .rdata_vld(rdata_vld),
        .ctrl_byte(ctrl_byte),
        .fdc_byte (fdc_byte),
        .pp_byte  (pp_byte)
    );

    cfgbank_enables u_en (
        .ctrl_byte  (ctrl_byte),
        .ser_en     (ser_en),
        .fdc_en     (fdc_en),
        .pp_en      (pp_en),
        .pp_out_only(pp_out_only),
        .win_sel    (win_sel)
    );

    cfgbank_window u_win (
        .win_sel  (win_sel),
        .dma      (port_dma),
        .enable   (pp_en),
        .port_addr(port_addr),
        .base     (pp_base),
        .hit      (port_hit)
    );

    // Arbitration fields straight from the stored bytes.
    assign fdc_arb       = fdc_byte[ARB_W-1:0];
    assign fdc_fair_en   = fdc_byte[ARB_W];
    assign fdc_burst_dis = fdc_byte[ARB_W+1];
    assign pp_arb        = pp_byte[ARB_W-1:0];
    assign pp_irq_lvl    = LVL_W'(PP_IRQ_LEVEL);

    // Interrupt requests bypass every enable, one line at a time.
    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        assign irq_out[i] = irq_in[i];
    end

endmodule

// File: rtl/setup_cfg_bank_chk.sv
// Assertion checker for setup_cfg_bank, attached by bind.
module setup_cfg_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        setup_en,
    input logic        wr_en,
    input logic        rd_en,
    input logic [1:0]  reg_sel,
    input logic [7:0]  rdata,
    input logic        rdata_vld,
    input logic        ser_en,
    input logic        fdc_en,
    input logic        pp_en,
    input logic        pp_out_only,
    input logic        fdc_burst_dis,
    input logic        fdc_fair_en,
    input logic [3:0]  fdc_arb,
    input logic [3:0]  pp_arb,
    input logic [15:0] pp_base,
    input logic [15:0] port_addr,
    input logic        port_hit
);
    // R1
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_en |-> (rdata == 8'h00 && !rdata_vld));

    // R1
    wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(setup_en && wr_en) |=> ($stable(ser_en) && $stable(fdc_en) && $stable(pp_en)
            && $stable(pp_out_only) && $stable(fdc_arb) && $stable(pp_arb)
            && $stable(fdc_fair_en) && $stable(fdc_burst_dis)));

    // R3
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_en && rd_en && reg_sel == 2'd0) |-> rdata[3:2] == 2'b10);

    // R4
    pp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_en && rd_en && reg_sel == 2'd0) |-> (pp_en == (rdata[4] & rdata[0])
            && fdc_en == (rdata[1] & rdata[0])));

    // R5
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |-> (!fdc_en && !pp_en && !port_hit));

    // R9
    hit_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |-> pp_en);

    // R9
    hit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_hit |-> port_addr >= pp_base);

    // R10
    fdc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_en && rd_en && reg_sel == 2'd1) |-> (rdata[3:0] == fdc_arb
            && rdata[4] == fdc_fair_en && rdata[5] == fdc_burst_dis && rdata[7:6] == 2'b00));

endmodule

bind setup_cfg_bank setup_cfg_bank_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .setup_en     (setup_en),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .reg_sel      (reg_sel),
    .rdata        (rdata),
    .rdata_vld    (rdata_vld),
    .ser_en       (ser_en),
    .fdc_en       (fdc_en),
    .pp_en        (pp_en),
    .pp_out_only  (pp_out_only),
    .fdc_burst_dis(fdc_burst_dis),
    .fdc_fair_en  (fdc_fair_en),
    .fdc_arb      (fdc_arb),
    .pp_arb       (pp_arb),
    .pp_base      (pp_base),
    .port_addr    (port_addr),
    .port_hit     (port_hit)
);

// File: tb/tb_setup_cfg_bank.sv
module tb_setup_cfg_bank;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        setup_en = 0, wr_en = 0, rd_en = 0, port_dma = 0;
    logic [1:0]  reg_sel = 0;
    logic [7:0]  wdata = 0;
    logic [15:0] port_addr = 0;
    logic [3:0]  irq_in = 0;
    logic [7:0]  rdata;
    logic        rdata_vld, ser_en, fdc_en, pp_en, pp_out_only, fdc_burst_dis, fdc_fair_en, port_hit;
    logic [3:0]  fdc_arb, pp_arb, pp_irq_lvl, irq_out;
    logic [15:0] pp_base;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    setup_cfg_bank dut (.*);

    // {setup, reg_sel, wdata, expected readback}
    localparam logic [18:0] VEC [10] = '{
        {1'b1, 2'd0, 8'hFF, 8'hFB},   // R3 fixed bits
        {1'b0, 2'd0, 8'h00, 8'hFB},   // R1 ignored
        {1'b1, 2'd0, 8'h04, 8'h08},   // R3
        {1'b1, 2'd1, 8'hFF, 8'h3F},   // R10 reserved
        {1'b0, 2'd1, 8'h00, 8'h3F},   // R1
        {1'b1, 2'd1, 8'h15, 8'h15},   // R10
        {1'b1, 2'd2, 8'hA5, 8'h05},   // R11
        {1'b0, 2'd2, 8'h0F, 8'h05},   // R1
        {1'b1, 2'd3, 8'hFF, 8'h00},   // R2 unused select
        {1'b1, 2'd0, 8'h31, 8'h39}    // R2
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic s, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        setup_en = s; wr_en = 1; reg_sel = a; wdata = d;
        @(negedge clk);
        wr_en = 0; setup_en = 1;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        setup_en = 1; rd_en = 1; reg_sel = a;
        #1 d = rdata;
        rd_en = 0;
        #1;
    endtask

    function automatic logic [15:0] lo_of(input int s, input logic dma);
        case (s)
            0: return dma ? 16'h1278 : 16'h03BC;
            1: return 16'h0378;
            2: return 16'h0278;
            default: return 16'h1378;
        endcase
    endfunction

    function automatic logic [15:0] hi_of(input int s, input logic dma);
        case (s)
            0: return dma ? 16'h127D : 16'h03BF;
            1: return 16'h037D;
            2: return 16'h027D;
            default: return 16'h137D;
        endcase
    endfunction

    task automatic win_check(input int s, input logic dma);
        logic [15:0] lo, hi;
        lo = lo_of(s, dma); hi = hi_of(s, dma);
        port_dma = dma;
        port_addr = lo;     #1 chk("R7 base", pp_base, lo);
                               chk("R9 hit low end", port_hit, 1);
        port_addr = hi;     #1 chk("R9 hit high end", port_hit, 1);
        port_addr = lo - 1; #1 chk("R9 below", port_hit, 0);
        port_addr = hi + 1; #1 chk("R9 above", port_hit, 0);
        port_dma = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R13 reset values
        rd(2'd0, d); chk("R13 ctrl", d, 8'h08);
        rd(2'd1, d); chk("R13 fdc arb", d, 8'h02);
        rd(2'd2, d); chk("R13 pp arb", d, 8'h00);
        chk("R6 reset bidirectional", pp_out_only, 0);
        chk("R13 fdc_arb", fdc_arb, 4'd2);
        chk("R5 reset master off", {ser_en, fdc_en, pp_en}, 3'b000);
        // R1 read gating
        setup_en = 0; rd_en = 1; reg_sel = 0; #1;
        chk("R1 rdata off", rdata, 8'h00);
        chk("R1 valid off", rdata_vld, 0);
        rd_en = 0;

        // table walk
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][18], VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], d);
            chk("R1/R2/R3/R10/R11 table", d, VEC[i][7:0]);
        end
        // decoded from last writes: fdc 0x15, pp 0x05, ctrl 0x39
        chk("R10 fdc_arb", fdc_arb, 4'd5);
        chk("R10 fairness", fdc_fair_en, 1);
        chk("R10 burst", fdc_burst_dis, 0);
        chk("R11 pp_arb", pp_arb, 4'd5);
        chk("R4 pp_en", pp_en, 1);
        chk("R4 fdc_en off", fdc_en, 0);

        // R4 / R5 enable combinations
        wr(1, 0, 8'h13); chk("R4 both on", {ser_en, fdc_en, pp_en}, 3'b111);
        wr(1, 0, 8'h12); chk("R5 master off", {ser_en, fdc_en, pp_en}, 3'b000);
        wr(1, 0, 8'h03); chk("R4 fdc only", {fdc_en, pp_en}, 2'b10);
        wr(1, 0, 8'h91); chk("R6 output only", pp_out_only, 1);
        wr(1, 1, 8'h22); chk("R10 burst disable", fdc_burst_dis, 1);

        // R7 / R8 / R9 windows
        for (int s = 0; s < 4; s++) begin
            wr(1, 0, 8'h11 | 8'(s << 5));
            win_check(s, 0);
            chk("R7 irq level", pp_irq_lvl, 4'd7);
        end
        wr(1, 0, 8'h11);
        win_check(0, 1);   // R8 DMA alias
        wr(1, 0, 8'h31);
        port_dma = 1; port_addr = 16'h0378; #1
        chk("R8 dma ignored sel 01", port_hit, 1);
        port_addr = 16'h1278; #1 chk("R8 no alias sel 01", port_hit, 0);
        port_dma = 0;

        // R9 / R5 hit forced low
        wr(1, 0, 8'h01); port_addr = 16'h03BC; #1 chk("R9 port disabled", port_hit, 0);
        wr(1, 0, 8'h10); #1 chk("R5 master off hit", port_hit, 0);

        // R12 pass-through with master off
        irq_in = 4'b1010; #1 chk("R12 irq", irq_out, 4'b1010);
        irq_in = 4'b0101; #1 chk("R12 irq", irq_out, 4'b0101);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule